// File: doc/BRIEF.md
# Scalar Integer ALU Execute Stage

This block is the integer execute unit of a scalar core. Each cycle it takes one 24-bit three-register instruction word, the values already read for its two source registers, the current value of the destination register and a 16-entry boolean vector. It decodes the word, computes the 32-bit destination value and a write-enable, and registers both (plus an illegal-instruction flag) on the next rising clock edge. The register file, shifters, immediates and hazard logic live elsewhere; this unit only computes.

The operation set is add and subtract, the scaled address forms that shift the first source left by 1, 2 or 3 before adding or subtracting, bitwise AND/OR/XOR, negate and absolute value, signed and unsigned set-on-less-than, and predicated moves. Nothing produces a flag: every result wraps modulo 2^32. The predicated moves are read-modify-write: on a false predicate the unit passes the incoming destination value through with the write-enable low, so the caller can either write it or skip the write.

Top module: `scalar_alu_ex`

## Requirements
- R1: The instruction word is v with op0=v[3:0], t=v[7:4], s=v[11:8], r=v[15:12], op1=v[19:16], op2=v[23:20]; every legal operation has op0=0, and op1 picks the group (0 arithmetic/logic, 2 compare, 3 predicated move) before op2 picks the operation.
- R2: With op1=0, op2=8 gives s+t, op2=9/10/11 give (s<<1/2/3)+t, op2=12 gives s-t and op2=13/14/15 give (s<<1/2/3)-t, all modulo 2^32 with write-enable high.
- R3: With op1=0, op2=1/2/3 give s AND t, s OR t and s XOR t respectively, write-enable high.
- R4: With op1=0 and op2=6, an s field of 0 gives the two's-complement negation of t and an s field of 1 gives its absolute value; both map 0x80000000 to 0x80000000.
- R5: With op1=2, op2=6 writes 1 if s<t unsigned and 0 otherwise; op2=7 does the same with a signed compare.
- R6: With op1=3, op2=8/9/10/11 move s when t==0, t!=0, t<0 signed or t>=0 signed respectively; when the condition is false the result is the incoming destination value and write-enable is low.
- R7: With op1=3, op2=13 moves s when bool_i[t field] is 1 and op2=12 moves s when it is 0; otherwise the result is the incoming destination value with write-enable low.
- R8: Any other combination of op0, op1, op2 (and s for op1=0, op2=6) raises illegal_o with write-enable low and a result of 0.
- R9: Result, write-enable and illegal flag are registered on the rising clock edge; a synchronous active-low reset clears all three to 0.
- R10: The unit accepts a new instruction every cycle; the output after each edge reflects only the instruction presented in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_i | input | 24 | Instruction word, byte 0 in bits 7:0 |
| src_s_i | input | 32 | Value of the register named by the s field |
| src_t_i | input | 32 | Value of the register named by the t field |
| dst_old_i | input | 32 | Current value of the register named by the r field |
| bool_i | input | 16 | Boolean register vector indexed by the t field |
| result_o | output | 32 | Registered destination value |
| wr_en_o | output | 1 | Registered destination write-enable |
| illegal_o | output | 1 | Registered illegal-instruction flag |

## Verification
Every result, write-enable and illegal flag is due exactly one rising edge after its instruction and operands are presented, with no further latency for any operation. The bench drives a new instruction on each falling edge and pushes the expected outcome into a queue; a monitor pops one entry shortly after each rising edge, so back-to-back instructions are each compared in the cycle they are due. Reset is checked the same way, one edge after rst_n is driven low.

// File: rtl/scalar_alu_pkg.sv
// Package: shared types of the scalar ALU execute stage.
// Assumes a 24-bit instruction word and a 16-entry boolean vector.
package scalar_alu_pkg;

    localparam int INSTR_W = 24;
    localparam int NIB_W   = 4;
    localparam int NBOOL   = 1 << NIB_W;

    typedef enum logic [3:0] {
        K_AND, K_OR, K_XOR, K_ADD, K_SUB, K_NEG, K_ABS, K_SLTU,
        K_SLT, K_MEQZ, K_MNEZ, K_MLTZ, K_MGEZ, K_MOVF, K_MOVT, K_ILL
    } op_kind_e;

    typedef struct packed {
        op_kind_e         kind;
        logic [1:0]       scale;
        logic [NIB_W-1:0] bsel;
    } dec_t;

endpackage

// File: rtl/alu_decode.sv
// Module: alu_decode
// Splits the instruction word into nibbles and maps the op0/op1/op2
// (and s for the negate group) combination onto an operation kind.
// Assumes op0 must be zero for every legal operation.
module alu_decode
    import scalar_alu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output dec_t               dec_o
);
    logic [NIB_W-1:0] op0, fld_t, fld_s, op1, op2;

    assign op0   = instr_i[3:0];
    assign fld_t = instr_i[7:4];
    assign fld_s = instr_i[11:8];
    assign op1   = instr_i[19:16];
    assign op2   = instr_i[23:20];

    // Purpose: pick the operation kind and the scale for the address forms.
    always_comb begin
        dec_o.kind  = K_ILL;
        dec_o.scale = 2'd0;
        dec_o.bsel  = fld_t;
        if (op0 == 4'd0) begin
            unique case (op1)
                4'd0: begin
                    case (op2)
                        4'd1: dec_o.kind = K_AND;
                        4'd2: dec_o.kind = K_OR;
                        4'd3: dec_o.kind = K_XOR;
                        4'd6: begin
                            if (fld_s == 4'd0)      dec_o.kind = K_NEG;
                            else if (fld_s == 4'd1) dec_o.kind = K_ABS;
                        end
                        4'd8, 4'd9, 4'd10, 4'd11: begin
                            dec_o.kind  = K_ADD;
                            dec_o.scale = op2[1:0];
                        end
                        4'd12, 4'd13, 4'd14, 4'd15: begin
                            dec_o.kind  = K_SUB;
                            dec_o.scale = op2[1:0];
                        end
                        default: dec_o.kind = K_ILL;
                    endcase
                end
                4'd2: begin
                    if (op2 == 4'd6)      dec_o.kind = K_SLTU;
                    else if (op2 == 4'd7) dec_o.kind = K_SLT;
                end
                4'd3: begin
                    case (op2)
                        4'd8:    dec_o.kind = K_MEQZ;
                        4'd9:    dec_o.kind = K_MNEZ;
                        4'd10:   dec_o.kind = K_MLTZ;
                        4'd11:   dec_o.kind = K_MGEZ;
                        4'd12:   dec_o.kind = K_MOVF;
                        4'd13:   dec_o.kind = K_MOVT;
                        default: dec_o.kind = K_ILL;
                    endcase
                end
                default: dec_o.kind = K_ILL;
            endcase
        end
    end
endmodule

// File: rtl/alu_arith.sv
// Module: alu_arith
// Wrapping arithmetic, logic and compare datapath. Produces a value for
// every kind; the caller decides whether it is used. No flags exist.
module alu_arith
    import scalar_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  op_kind_e        kind_i,
    input  logic [1:0]      scale_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] res_o
);
    logic [XLEN-1:0] a_scaled;
    logic [XLEN-1:0] b_neg;

    assign a_scaled = a_i << scale_i;
    assign b_neg    = '0 - b_i;

    // Purpose: select the arithmetic or logic result for the kind.
    always_comb begin
        unique case (kind_i)
            K_AND:   res_o = a_i & b_i;
            K_OR:    res_o = a_i | b_i;
            K_XOR:   res_o = a_i ^ b_i;
            K_ADD:   res_o = a_scaled + b_i;
            K_SUB:   res_o = a_scaled - b_i;
            K_NEG:   res_o = b_neg;
            K_ABS:   res_o = b_i[XLEN-1] ? b_neg : b_i;
            K_SLTU:  res_o = {{(XLEN-1){1'b0}}, (a_i < b_i)};
            K_SLT:   res_o = {{(XLEN-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_cmov.sv
// Module: alu_cmov
// Evaluates the predicate of a conditional move: a zero/sign test on the
// t operand or a lookup in the boolean vector. Non-move kinds give is_move=0.
module alu_cmov
    import scalar_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  op_kind_e         kind_i,
    input  logic [NIB_W-1:0] bsel_i,
    input  logic [XLEN-1:0]  t_i,
    input  logic [NBOOL-1:0] bool_i,
    output logic             is_move_o,
    output logic             take_o
);
    logic t_zero;
    logic t_neg;
    logic bit_sel;

    assign t_zero  = (t_i == '0);
    assign t_neg   = t_i[XLEN-1];
    assign bit_sel = bool_i[bsel_i];

    // Purpose: decide whether the move happens.
    always_comb begin
        is_move_o = 1'b1;
        unique case (kind_i)
            K_MEQZ: take_o = t_zero;
            K_MNEZ: take_o = !t_zero;
            K_MLTZ: take_o = t_neg;
            K_MGEZ: take_o = !t_neg;
            K_MOVT: take_o = bit_sel;
            K_MOVF: take_o = !bit_sel;
            default: begin
                is_move_o = 1'b0;
                take_o    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/scalar_alu_ex.sv
// Module: scalar_alu_ex
// Top of the execute stage: decode, datapath, predicate, then one
// output register. Assumes operands are already read by the caller and
// that the caller honours wr_en_o. Reset is synchronous, active low.
module scalar_alu_ex
    import scalar_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [XLEN-1:0]    src_s_i,
    input  logic [XLEN-1:0]    src_t_i,
    input  logic [XLEN-1:0]    dst_old_i,
    input  logic [NBOOL-1:0]   bool_i,
    output logic [XLEN-1:0]    result_o,
    output logic               wr_en_o,
    output logic               illegal_o
);
    dec_t            dec;
    logic [XLEN-1:0] arith_res;
    logic            is_move;
    logic            take;
    logic [XLEN-1:0] nxt_res;
    logic            nxt_we;
    logic            nxt_ill;

    alu_decode u_dec (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    alu_arith #(.XLEN(XLEN)) u_arith (
        .kind_i  (dec.kind),
        .scale_i (dec.scale),
        .a_i     (src_s_i),
        .b_i     (src_t_i),
        .res_o   (arith_res)
    );

    alu_cmov #(.XLEN(XLEN)) u_cmov (
        .kind_i    (dec.kind),
        .bsel_i    (dec.bsel),
        .t_i       (src_t_i),
        .bool_i    (bool_i),
        .is_move_o (is_move),
        .take_o    (take)
    );

    // Purpose: merge datapath, move and illegal paths into the next output.
    always_comb begin
        if (dec.kind == K_ILL) begin
            nxt_res = '0;
            nxt_we  = 1'b0;
            nxt_ill = 1'b1;
        end else if (is_move) begin
            nxt_res = take ? src_s_i : dst_old_i;
            nxt_we  = take;
            nxt_ill = 1'b0;
        end else begin
            nxt_res = arith_res;
            nxt_we  = 1'b1;
            nxt_ill = 1'b0;
        end
    end

    // Purpose: output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            wr_en_o   <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            result_o  <= nxt_res;
            wr_en_o   <= nxt_we;
            illegal_o <= nxt_ill;
        end
    end
endmodule

// File: rtl/alu_ex_checker.sv
// Module: alu_ex_checker
// Temporal checks on the ports of scalar_alu_ex, attached by bind.
module alu_ex_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [23:0]     instr_i,
    input logic [XLEN-1:0] src_s_i,
    input logic [XLEN-1:0] src_t_i,
    input logic [XLEN-1:0] dst_old_i,
    input logic [XLEN-1:0] result_o,
    input logic            wr_en_o,
    input logic            illegal_o
);
    logic is_add, is_meqz, is_cmp, is_abs;

    assign is_add  = (instr_i[3:0] == 4'd0) && (instr_i[19:16] == 4'd0) && (instr_i[23:20] == 4'd8);
    assign is_meqz = (instr_i[3:0] == 4'd0) && (instr_i[19:16] == 4'd3) && (instr_i[23:20] == 4'd8);
    assign is_cmp  = (instr_i[3:0] == 4'd0) && (instr_i[19:16] == 4'd2) && (instr_i[23:21] == 3'd3);
    assign is_abs  = (instr_i[3:0] == 4'd0) && (instr_i[19:16] == 4'd0) && (instr_i[23:20] == 4'd6)
                     && (instr_i[11:8] == 4'd1);

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !wr_en_o); // R8

    AST_ADD_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        is_add |=> (wr_en_o && result_o == $past(src_s_i + src_t_i))); // R2

    AST_ABS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        is_abs |=> (!result_o[XLEN-1] || result_o == {1'b1, {(XLEN-1){1'b0}}})); // R4

    AST_CMP_ZERO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |=> (result_o[XLEN-1:1] == '0 && wr_en_o)); // R5

    AST_MOVE_FALSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_meqz && src_t_i != '0) |=> (!wr_en_o && result_o == $past(dst_old_i))); // R6

endmodule

bind scalar_alu_ex alu_ex_checker #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_i   (instr_i),
    .src_s_i   (src_s_i),
    .src_t_i   (src_t_i),
    .dst_old_i (dst_old_i),
    .result_o  (result_o),
    .wr_en_o   (wr_en_o),
    .illegal_o (illegal_o)
);

// File: tb/sim_scalar_alu_ex.sv
// Scoreboard bench: driver pushes expectations, monitor pops and compares.
module sim_scalar_alu_ex;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] instr = '0;
    logic [31:0] vs = '0, vt = '0, vd = '0;
    logic [15:0] bv = '0;
    logic [31:0] result;
    logic        wr_en, illegal;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] res;
        logic        we;
        logic        ill;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    scalar_alu_ex u0 (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .src_s_i(vs), .src_t_i(vt),
        .dst_old_i(vd), .bool_i(bv), .result_o(result), .wr_en_o(wr_en), .illegal_o(illegal)
    );

    function automatic logic [23:0] mk(input logic [3:0] op2, input logic [3:0] op1,
                                       input logic [3:0] s, input logic [3:0] t,
                                       input logic [3:0] op0 = 4'd0);
        return {op2, op1, 4'd5, s, t, op0};
    endfunction

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [23:0] w, input logic [31:0] a,
                                   input logic [31:0] b, input logic [31:0] d,
                                   input logic [15:0] bb);
        exp_t e;
        logic [3:0] o0, o1, o2, fs, ft;
        logic hit;
        o0 = w[3:0]; ft = w[7:4]; fs = w[11:8]; o1 = w[19:16]; o2 = w[23:20];
        e.res = '0; e.we = 1'b1; e.ill = 1'b0; e.tag = "";
        if (o0 != 0) begin e.we = 0; e.ill = 1; return e; end
        if (o1 == 0) begin
            if (o2 == 1) e.res = a & b;
            else if (o2 == 2) e.res = a | b;
            else if (o2 == 3) e.res = a ^ b;
            else if (o2 == 6 && fs == 0) e.res = 32'd0 - b;
            else if (o2 == 6 && fs == 1) e.res = ($signed(b) < 0) ? 32'd0 - b : b;
            else if (o2 >= 8 && o2 <= 11) e.res = a * (32'd1 << (o2 - 8)) + b;
            else if (o2 >= 12) e.res = a * (32'd1 << (o2 - 12)) - b;
            else begin e.we = 0; e.ill = 1; end
        end else if (o1 == 2 && (o2 == 6 || o2 == 7)) begin
            if (o2 == 6) e.res = (a < b) ? 32'd1 : 32'd0;
            else e.res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        end else if (o1 == 3 && o2 >= 8 && o2 <= 13) begin
            case (o2)
                8: hit = (b == 0);
                9: hit = (b != 0);
                10: hit = ($signed(b) < 0);
                11: hit = ($signed(b) >= 0);
                12: hit = (bb[ft] == 0);
                default: hit = (bb[ft] == 1);
            endcase
            e.res = hit ? a : d;
            e.we = hit;
        end else begin
            e.we = 0; e.ill = 1;
        end
        return e;
    endfunction

    task automatic drive(input string tag, input logic [23:0] w, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] d = 32'hD0D0_D0D0,
                         input logic [15:0] bb = 16'h0);
        exp_t e;
        @(negedge clk);
        instr = w; vs = a; vt = b; vd = d; bv = bb;
        e = model(w, a, b, d, bb);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: one result is due one rising edge after each drive.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, {result, wr_en, illegal}, {e.res, e.we, e.ill});
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R9: reset clears the outputs
        instr = mk(4'd8, 4'd0, 0, 0); vs = 32'h1234; vt = 32'h1;
        repeat (2) @(posedge clk);
        #1 check("R9 reset state", {result, wr_en, illegal}, 34'd0);
        @(negedge clk); rst_n = 1'b1;

        drive("R2 add wrap", mk(4'd8, 4'd0, 1, 2), 32'hFFFF_FFFF, 32'h1);
        drive("R2 addx4", mk(4'd10, 4'd0, 1, 2), 32'h4000_0001, 32'h10);
        drive("R2 addx8", mk(4'd11, 4'd0, 1, 2), 32'h3, 32'h7);
        drive("R2 sub wrap", mk(4'd12, 4'd0, 1, 2), 32'h0, 32'h1);
        drive("R2 subx2", mk(4'd13, 4'd0, 1, 2), 32'h10, 32'h5);
        drive("R2 subx8", mk(4'd15, 4'd0, 1, 2), 32'h2, 32'h20);
        drive("R3 and", mk(4'd1, 4'd0, 1, 2), 32'hF0F0_1234, 32'hFF00_FF00);
        drive("R3 or", mk(4'd2, 4'd0, 1, 2), 32'hF0F0_1234, 32'h0F00_0001);
        drive("R3 xor", mk(4'd3, 4'd0, 1, 2), 32'hAAAA_5555, 32'hFFFF_0000);
        drive("R4 neg", mk(4'd6, 4'd0, 0, 2), 32'h0, 32'd5);
        drive("R4 neg min", mk(4'd6, 4'd0, 0, 2), 32'h0, 32'h8000_0000);
        drive("R4 abs neg", mk(4'd6, 4'd0, 1, 2), 32'h0, 32'hFFFF_FFF9);
        drive("R4 abs pos", mk(4'd6, 4'd0, 1, 2), 32'h0, 32'd9);
        drive("R4 abs min", mk(4'd6, 4'd0, 1, 2), 32'h0, 32'h8000_0000);
        drive("R5 slt signed", mk(4'd7, 4'd2, 1, 2), 32'hFFFF_FFFF, 32'h1);
        drive("R5 sltu unsigned", mk(4'd6, 4'd2, 1, 2), 32'hFFFF_FFFF, 32'h1);
        drive("R5 sltu true", mk(4'd6, 4'd2, 1, 2), 32'h1, 32'hFFFF_FFFF);
        drive("R5 slt equal", mk(4'd7, 4'd2, 1, 2), 32'h7, 32'h7);
        drive("R6 moveqz true", mk(4'd8, 4'd3, 1, 2), 32'h1111, 32'h0, 32'h9999);
        drive("R6 moveqz false", mk(4'd8, 4'd3, 1, 2), 32'h1111, 32'h3, 32'h9999);
        drive("R6 movnez true", mk(4'd9, 4'd3, 1, 2), 32'h2222, 32'h3, 32'h9999);
        drive("R6 movltz true", mk(4'd10, 4'd3, 1, 2), 32'h3333, 32'h8000_0000, 32'h9999);
        drive("R6 movltz false", mk(4'd10, 4'd3, 1, 2), 32'h3333, 32'h7FFF_FFFF, 32'h9999);
        drive("R6 movgez zero", mk(4'd11, 4'd3, 1, 2), 32'h4444, 32'h0, 32'h9999);
        drive("R7 movt true", mk(4'd13, 4'd3, 1, 4'd9), 32'h5555, 32'h0, 32'h8888, 16'h0200);
        drive("R7 movt false", mk(4'd13, 4'd3, 1, 4'd9), 32'h5555, 32'h0, 32'h8888, 16'hFDFF);
        drive("R7 movf true", mk(4'd12, 4'd3, 1, 4'd2), 32'h6666, 32'h1, 32'h8888, 16'hFFFB);
        drive("R7 movf false", mk(4'd12, 4'd3, 1, 4'd2), 32'h6666, 32'h1, 32'h8888, 16'h0004);
        drive("R8 op0 nonzero", mk(4'd8, 4'd0, 1, 2, 4'd1), 32'h1, 32'h1);
        drive("R8 op2 zero", mk(4'd0, 4'd0, 1, 2), 32'h1, 32'h1);
        drive("R8 neg group s=2", mk(4'd6, 4'd0, 2, 2), 32'h1, 32'h1);
        drive("R8 move op2=14", mk(4'd14, 4'd3, 1, 2), 32'h1, 32'h0);
        drive("R8 op1=1", mk(4'd8, 4'd1, 1, 2), 32'h1, 32'h1);
        // R1: op1 selects the group, s selects within op2=6
        drive("R1 op1=0 op2=6 abs", mk(4'd6, 4'd0, 1, 2), 32'h5, 32'hFFFF_FFFE);
        drive("R1 op1=2 op2=6 cmp", mk(4'd6, 4'd2, 1, 2), 32'h5, 32'hFFFF_FFFE);
        // R10: dependent back-to-back results, one per cycle
        drive("R10 b2b first", mk(4'd8, 4'd0, 1, 2), 32'd10, 32'd20);
        drive("R10 b2b second", mk(4'd12, 4'd0, 1, 2), 32'd30, 32'd100);
        drive("R10 b2b third", mk(4'd3, 4'd0, 1, 2), 32'hFFFF_FF9A, 32'h0000_00FF);
        @(negedge clk);
        // R9: reset in mid-run clears the register
        drive("R9 pre-reset add", mk(4'd8, 4'd0, 1, 2), 32'd1, 32'd2);
        @(negedge clk);
        instr = mk(4'd8, 4'd0, 1, 2); vs = 32'd7; vt = 32'd7;
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R9 reset mid-run", {result, wr_en, illegal}, 34'd0);
        @(negedge clk); rst_n = 1'b1;
        drive("R9 after reset", mk(4'd1, 4'd0, 1, 2), 32'hF, 32'h3);
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule